// File: doc/BRIEF.md
# Coalesced-Interrupt Acknowledge Tracker

This block keeps account of the end-of-interrupt acknowledgements still owed for one edge-triggered interrupt line that is fanned out to several destinations. When the line is delivered, the block stores which destinations took the interrupt and the vector each one received. It also loads a pending count equal to the number of those destinations. Each destination then acknowledges by sending its index and a vector. A matching acknowledge retires that destination and lowers the count.

While the count is nonzero, the `coalesced` output is high. Logic upstream uses it to report a fresh assertion of the line as merged into the one still in flight, and the tracker refuses new deliveries during that time. A synchronous clear drops all tracking. A per-destination restore port lets the surrounding logic bring one destination's entry back in line with an externally known pending flag, for example after state has been reloaded. If a retire would take the count below zero, the count is rebuilt from the remaining pending bits.

Top module: `eoi_trk`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `coalesced` is 0.
- R2: `coalesced` is high exactly when the pending count is nonzero. The pending count always equals the number of set bits in the destination map, so `coalesced` changes in the cycle after the operation that changes the count.
- R3: A delivery (`dlvValid`) accepted while the count is zero replaces the destination map with `dlvMask`. Bit i of `dlvMask` stands for destination index i. The delivery records `dlvVector` for every destination in the mask and loads the count with the population of the mask. An all-zero mask means the delivery failed, and the count stays zero.
- R4: A delivery presented while `coalesced` is high is dropped. The map, the vectors and the count are left unchanged.
- R5: An acknowledge (`eoiValid`, `eoiDest`, `eoiVector`) whose destination bit is set and whose vector equals the vector recorded for that destination clears that bit and decrements the count.
- R6: An acknowledge whose destination bit is clear, or whose vector differs from the recorded one, has no effect.
- R7: `clrTrack` clears the whole destination map and the count in the next cycle.
- R8: A restore (`rstoValid`, `rstoDest`) with `rstoPending`=1 for a destination whose bit is clear sets the bit, records `rstoVector` for that destination and increments the count. A restore whose flag equals the stored bit does nothing.
- R9: A restore with `rstoPending`=0 for a destination whose bit is set clears the bit and decrements the count.
- R10: Only one operation takes effect per cycle, chosen in this priority: clear, delivery, restore, acknowledge. A lower-priority request in the same cycle is discarded. This holds even when the delivery is itself dropped under R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clrTrack | input | 1 | Drop all tracking state |
| dlvValid | input | 1 | Delivery event |
| dlvMask | input | NDEST | Destinations that accepted the delivery |
| dlvVector | input | VEC_W | Vector sent with the delivery |
| eoiValid | input | 1 | Acknowledge event |
| eoiDest | input | IDX_W | Acknowledging destination index |
| eoiVector | input | VEC_W | Vector being acknowledged |
| rstoValid | input | 1 | Restore event for one destination |
| rstoDest | input | IDX_W | Destination being restored |
| rstoPending | input | 1 | Externally known pending flag for that destination |
| rstoVector | input | VEC_W | Vector to record when the bit is set |
| coalesced | output | 1 | High while any acknowledge is outstanding |

## Verification
A wrong destination bit or a wrong stored vector stays hidden until that destination acknowledges. At that point `coalesced` falls too early, when a mismatched acknowledge retires an entry, or never falls, when a correct acknowledge is refused. The bench therefore ends each scenario by retiring every destination and watches the cycle where the flag drops. A count that drifts from the bitmap shows up one cycle after the operation as a flag at the wrong level. A reference model compared on every clock pins that down to the exact cycle.

// File: rtl/eoi_trk_pkg.sv
package eoi_trk_pkg;
  // strobes from the control to the datapath, one operation per cycle
  typedef struct packed {
    logic clear;    // wipe map and count
    logic load;     // take a delivery
    logic setBit;   // restore sets one destination
    logic clrBit;   // acknowledge or restore clears one destination
    logic useRsto;  // index comes from the restore port
  } trkStrobe_t;
endpackage

// File: rtl/eoi_trk_ctrl.sv
module eoi_trk_ctrl (
  input  logic                     clrTrack,
  input  logic                     dlvValid,
  input  logic                     eoiValid,
  input  logic                     rstoValid,
  input  logic                     rstoPending,
  input  logic                     cntZero,
  input  logic                     eoiHit,
  input  logic                     rstoBit,
  output eoi_trk_pkg::trkStrobe_t  st
);
  logic rstoTurn;
  logic eoiTurn;

  // R10: fixed priority clear > delivery > restore > acknowledge
  assign rstoTurn = !clrTrack && !dlvValid && rstoValid;
  assign eoiTurn  = !clrTrack && !dlvValid && !rstoValid && eoiValid;

  always_comb begin
    st         = '0;
    st.clear   = clrTrack;
    st.load    = !clrTrack && dlvValid && cntZero;
    st.useRsto = rstoTurn;
    st.setBit  = rstoTurn && rstoPending && !rstoBit;
    st.clrBit  = (rstoTurn && !rstoPending && rstoBit) || (eoiTurn && eoiHit);
  end
endmodule

// File: rtl/eoi_trk_dp.sv
module eoi_trk_dp #(
  parameter int NDEST = 16,
  parameter int VEC_W = 8,
  localparam int IDX_W = $clog2(NDEST),
  localparam int CNT_W = $clog2(NDEST + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  eoi_trk_pkg::trkStrobe_t  st,
  input  logic [NDEST-1:0]         dlvMask,
  input  logic [VEC_W-1:0]         dlvVector,
  input  logic [IDX_W-1:0]         eoiDest,
  input  logic [VEC_W-1:0]         eoiVector,
  input  logic [IDX_W-1:0]         rstoDest,
  input  logic [VEC_W-1:0]         rstoVector,
  output logic                     eoiHit,
  output logic                     rstoBit,
  output logic                     cntZero,
  output logic [NDEST-1:0]         pendMap,
  output logic [CNT_W-1:0]         pendCnt
);
  logic [VEC_W-1:0] vecMem [NDEST];
  logic [IDX_W-1:0] opIdx;
  logic [NDEST-1:0] oneHot;
  logic [NDEST-1:0] mapAfterClr;

  assign opIdx       = st.useRsto ? rstoDest : eoiDest;
  assign oneHot      = NDEST'(1) << opIdx;
  assign mapAfterClr = pendMap & ~oneHot;

  assign eoiHit  = pendMap[eoiDest] && (vecMem[eoiDest] == eoiVector);
  assign rstoBit = pendMap[rstoDest];
  assign cntZero = (pendCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMap <= '0;
      pendCnt <= '0;
    end else if (st.clear) begin
      pendMap <= '0;
      pendCnt <= '0;
    end else if (st.load) begin
      pendMap <= dlvMask;
      pendCnt <= CNT_W'($countones(dlvMask));
    end else if (st.setBit) begin
      pendMap <= pendMap | oneHot;
      pendCnt <= pendCnt + CNT_W'(1);
    end else if (st.clrBit) begin
      pendMap <= mapAfterClr;
      // underflow guard: rebuild the count from the surviving bits
      if (pendCnt == '0) pendCnt <= CNT_W'($countones(mapAfterClr));
      else               pendCnt <= pendCnt - CNT_W'(1);
    end
  end

  for (genvar i = 0; i < NDEST; i++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rstN)                                   vecMem[i] <= '0;
      else if (st.clear)                           vecMem[i] <= vecMem[i];
      else if (st.load && dlvMask[i])              vecMem[i] <= dlvVector;
      else if (st.setBit && opIdx == IDX_W'(i))    vecMem[i] <= rstoVector;
    end
  end
endmodule

// File: rtl/eoi_trk.sv
module eoi_trk #(
  parameter int NDEST = 16,
  parameter int VEC_W = 8,
  localparam int IDX_W = $clog2(NDEST),
  localparam int CNT_W = $clog2(NDEST + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrTrack,
  input  logic              dlvValid,
  input  logic [NDEST-1:0]  dlvMask,
  input  logic [VEC_W-1:0]  dlvVector,
  input  logic              eoiValid,
  input  logic [IDX_W-1:0]  eoiDest,
  input  logic [VEC_W-1:0]  eoiVector,
  input  logic              rstoValid,
  input  logic [IDX_W-1:0]  rstoDest,
  input  logic              rstoPending,
  input  logic [VEC_W-1:0]  rstoVector,
  output logic              coalesced
);
  eoi_trk_pkg::trkStrobe_t st;
  logic             eoiHit;
  logic             rstoBit;
  logic             cntZero;
  logic [NDEST-1:0] pendMap;
  logic [CNT_W-1:0] pendCnt;

  eoi_trk_ctrl u_ctrl (
    .clrTrack   (clrTrack),
    .dlvValid   (dlvValid),
    .eoiValid   (eoiValid),
    .rstoValid  (rstoValid),
    .rstoPending(rstoPending),
    .cntZero    (cntZero),
    .eoiHit     (eoiHit),
    .rstoBit    (rstoBit),
    .st         (st)
  );

  eoi_trk_dp #(.NDEST(NDEST), .VEC_W(VEC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .dlvMask   (dlvMask),
    .dlvVector (dlvVector),
    .eoiDest   (eoiDest),
    .eoiVector (eoiVector),
    .rstoDest  (rstoDest),
    .rstoVector(rstoVector),
    .eoiHit    (eoiHit),
    .rstoBit   (rstoBit),
    .cntZero   (cntZero),
    .pendMap   (pendMap),
    .pendCnt   (pendCnt)
  );

  // R2: flag follows the count
  assign coalesced = !cntZero;
endmodule

// File: rtl/eoi_trk_chk.sv
module eoi_trk_chk #(
  parameter int NDEST = 16,
  parameter int VEC_W = 8,
  localparam int IDX_W = $clog2(NDEST),
  localparam int CNT_W = $clog2(NDEST + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              clrTrack,
  input logic              dlvValid,
  input logic [NDEST-1:0]  dlvMask,
  input logic              eoiValid,
  input logic              rstoValid,
  input logic              rstoPending,
  input logic [IDX_W-1:0]  rstoDest,
  input logic              coalesced,
  input logic [NDEST-1:0]  pendMap,
  input logic [CNT_W-1:0]  pendCnt
);
  // R2
  cnt_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt == CNT_W'($countones(pendMap)));

  // R7
  clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrTrack |=> (pendMap == '0) && !coalesced);

  // R3
  take_dlv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clrTrack && dlvValid && !coalesced) |=> pendMap == $past(dlvMask));

  // R4
  ign_dlv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clrTrack && dlvValid && coalesced) |=> $stable(pendMap));

  // R5
  eoi_nogrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eoiValid && !clrTrack && !dlvValid && !rstoValid) |=> pendCnt <= $past(pendCnt));

  // R8
  rsto_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstoValid && rstoPending && !clrTrack && !dlvValid) |=> pendMap[$past(rstoDest)]);

  // R9
  rsto_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstoValid && !rstoPending && !clrTrack && !dlvValid) |=> !pendMap[$past(rstoDest)]);
endmodule

bind eoi_trk eoi_trk_chk #(.NDEST(NDEST), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clrTrack   (clrTrack),
  .dlvValid   (dlvValid),
  .dlvMask    (dlvMask),
  .eoiValid   (eoiValid),
  .rstoValid  (rstoValid),
  .rstoPending(rstoPending),
  .rstoDest   (rstoDest),
  .coalesced  (coalesced),
  .pendMap    (pendMap),
  .pendCnt    (pendCnt)
);

// File: tb/sim_eoi_trk.sv
`timescale 1ns/1ps
module sim_eoi_trk;
  localparam int ND = 16;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clrTrack = 1'b0;
  logic          dlvValid = 1'b0;
  logic [ND-1:0] dlvMask = '0;
  logic [VW-1:0] dlvVector = '0;
  logic          eoiValid = 1'b0;
  logic [3:0]    eoiDest = '0;
  logic [VW-1:0] eoiVector = '0;
  logic          rstoValid = 1'b0;
  logic [3:0]    rstoDest = '0;
  logic          rstoPending = 1'b0;
  logic [VW-1:0] rstoVector = '0;
  logic          coalesced;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  // behavioural reference
  bit mPend [ND];
  int mVec  [ND];
  int mCnt = 0;

  always #2 clk = ~clk;

  eoi_trk #(.NDEST(ND), .VEC_W(VW)) u0 (
    .clk(clk), .rstN(rstN), .clrTrack(clrTrack),
    .dlvValid(dlvValid), .dlvMask(dlvMask), .dlvVector(dlvVector),
    .eoiValid(eoiValid), .eoiDest(eoiDest), .eoiVector(eoiVector),
    .rstoValid(rstoValid), .rstoDest(rstoDest), .rstoPending(rstoPending),
    .rstoVector(rstoVector), .coalesced(coalesced)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0;
      for (int i = 0; i < ND; i++) begin mPend[i] = 1'b0; mVec[i] = 0; end
    end else if (clrTrack) begin
      mCnt = 0;
      for (int i = 0; i < ND; i++) mPend[i] = 1'b0;
    end else if (dlvValid) begin
      if (mCnt == 0) begin
        for (int i = 0; i < ND; i++) begin
          mPend[i] = dlvMask[i];
          if (dlvMask[i]) begin mVec[i] = int'(dlvVector); mCnt++; end
        end
      end
    end else if (rstoValid) begin
      if (rstoPending && !mPend[rstoDest]) begin
        mPend[rstoDest] = 1'b1; mVec[rstoDest] = int'(rstoVector); mCnt++;
      end else if (!rstoPending && mPend[rstoDest]) begin
        mPend[rstoDest] = 1'b0; mCnt--;
      end
    end else if (eoiValid) begin
      if (mPend[eoiDest] && mVec[eoiDest] == int'(eoiVector)) begin
        mPend[eoiDest] = 1'b0; mCnt--;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  task automatic cmp(input string tag, input bit expv);
    nChk++;
    if (coalesced !== expv) begin
      nBad++;
      $display("FAIL %s: coalesced=%0b expected=%0b at %0t", tag, coalesced, expv, $time);
    end
  endtask

  task automatic idle();
    clrTrack = 0; dlvValid = 0; eoiValid = 0; rstoValid = 0;
  endtask

  // one clock, then compare against the model 1ns after the edge
  task automatic cyc(input string tag);
    @(posedge clk); #1;
    cmp(tag, mCnt != 0);
    idle();
  endtask

  task automatic dlv(input string tag, input logic [ND-1:0] m, input logic [VW-1:0] v);
    dlvValid = 1; dlvMask = m; dlvVector = v; cyc(tag);
  endtask
  task automatic eoi(input string tag, input logic [3:0] d, input logic [VW-1:0] v);
    eoiValid = 1; eoiDest = d; eoiVector = v; cyc(tag);
  endtask
  task automatic rsto(input string tag, input logic [3:0] d, input bit p, input logic [VW-1:0] v);
    rstoValid = 1; rstoDest = d; rstoPending = p; rstoVector = v; cyc(tag);
  endtask

  initial begin
    for (int k = 0; k < 100000 && !done; k++) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    #1;
    cyc("R1"); cyc("R1");
    cmp("R1", 1'b0);
    rstN = 1;
    cyc("R1");

    // R3: deliver to 0,2,5
    dlv("R3", 16'h0025, 8'h31);
    cmp("R3", 1'b1);
    // R4: ignored while outstanding
    dlv("R4", 16'hFFFF, 8'h99);
    // R6: wrong vector and idle destination
    eoi("R6", 4'd0, 8'h30);
    eoi("R6", 4'd1, 8'h31);
    eoi("R6", 4'd1, 8'h99);
    // R5: retire one by one
    eoi("R5", 4'd0, 8'h31);
    eoi("R5", 4'd2, 8'h31);
    cmp("R5", 1'b1);
    eoi("R5", 4'd5, 8'h31);
    cmp("R5", 1'b0);
    // R3: failed delivery
    dlv("R3", 16'h0000, 8'h44);
    cmp("R3", 1'b0);

    // R8: restore set, repeat is a no-op, retire
    rsto("R8", 4'd7, 1'b1, 8'h55);
    rsto("R8", 4'd7, 1'b1, 8'h77);
    eoi("R8", 4'd7, 8'h77);
    eoi("R8", 4'd7, 8'h55);
    cmp("R8", 1'b0);

    // R9: restore clears
    dlv("R9", 16'h0003, 8'h10);
    rsto("R9", 4'd0, 1'b0, 8'h00);
    rsto("R9", 4'd3, 1'b0, 8'h00);
    eoi("R9", 4'd1, 8'h10);
    cmp("R9", 1'b0);

    // R7: clear
    dlv("R7", 16'hF0F0, 8'hA0);
    clrTrack = 1; cyc("R7");
    cmp("R7", 1'b0);
    eoi("R7", 4'd4, 8'hA0);

    // R10: priority
    clrTrack = 1; dlvValid = 1; dlvMask = 16'h0001; dlvVector = 8'h20; cyc("R10");
    dlvValid = 1; dlvMask = 16'h0001; dlvVector = 8'h22;
    rstoValid = 1; rstoDest = 4'd4; rstoPending = 1; rstoVector = 8'h01; cyc("R10");
    eoi("R10", 4'd0, 8'h22);
    cmp("R10", 1'b0);
    rstoValid = 1; rstoDest = 4'd0; rstoPending = 1; rstoVector = 8'h66;
    eoiValid = 1; eoiDest = 4'd0; eoiVector = 8'h66; cyc("R10");
    cmp("R10", 1'b1);
    dlvValid = 1; dlvMask = 16'h0002; dlvVector = 8'h01;
    eoiValid = 1; eoiDest = 4'd0; eoiVector = 8'h66; cyc("R10");
    eoi("R10", 4'd0, 8'h66);

    // R2: mixed traffic
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 99);
      clrTrack    = (r < 3);
      dlvValid    = (r >= 3 && r < 18);
      dlvMask     = 16'($urandom) & 16'($urandom);
      dlvVector   = 8'($urandom_range(0, 3));
      rstoValid   = (r >= 18 && r < 35);
      rstoDest    = 4'($urandom);
      rstoPending = 1'($urandom);
      rstoVector  = 8'($urandom_range(0, 3));
      eoiValid    = (r >= 30);
      eoiDest     = 4'($urandom);
      eoiVector   = 8'($urandom_range(0, 3));
      cyc("R2");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule